// File: doc/BRIEF.md
# Serial Register Access Port

This block is a synchronous serial slave that lets a host read and write a small file of byte-wide registers over four wires: a serial clock, an active-low chip select, a serial data input and a serial data output with an output enable. Every transaction is 16 serial clock cycles long. The first byte is a command: a 7-bit register address and a read/write flag. The second byte is the data. For a write, the host supplies the data byte. For a read, the block returns the addressed register's contents on the output.

The serial pins are sampled by the block's own system clock. Each input passes through a two-stage synchronizer, and the serial clock edges are detected from the synchronized copy. A static edge-select input chooses which serial clock edge launches output bits. Input bits are always captured on the opposite edge, which keeps setup and hold margin for the host in both settings. The output is presented as a data bit plus an enable, and the pad ring builds the three-state driver from that pair.

Top module: `serhost_port`

## Requirements
- R1: A frame is 16 bits, most significant bit first. The first 8 bits form the command byte: bits 7:1 are the register address and bit 0 is the read flag (1 = read, 0 = write). The last 8 bits are the data byte.
- R2: In a write frame, the full data byte is stored into the addressed register when the sixteenth bit is captured. A later read of that address returns it.
- R3: In a write frame, `sdoOe` is low while the command byte is received. From the first launch edge after the command byte, `sdoOe` is high and `sdoData` is 0.
- R4: In a read frame, `sdoOe` is low while the command byte is received. From the first launch edge after the command byte, `sdoOe` is high and the register byte is driven MSB first, one bit per launch edge.
- R5: With `edgeSel` = 1, SDI is captured on rising SCLK edges and SDO bits change on falling edges. With `edgeSel` = 0, SDI is captured on falling edges and SDO bits change on rising edges.
- R6: While `csN` is high, `sdoOe` is low and the bit count is held at zero. SCLK activity in that state has no effect, and the next frame starts from bit 0.
- R7: If `csN` rises before the sixteenth bit is captured, no register is written. If `csN` rises in the same system clock cycle as the sixteenth capture edge, no register is written either.
- R8: Addresses at or above NUM_REGS (8 by default) read as 0x00, and writes to them change no register.
- R9: After reset, every register holds 0x00 and `sdoOe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from the host |
| edgeSel | input | 1 | 1: launch SDO on falling SCLK; 0: launch on rising SCLK |
| sdoData | output | 1 | Serial data bit toward the host |
| sdoOe | output | 1 | Output enable for the SDO pad (0 = high impedance) |

## Verification
The interesting coincidence is the sixteenth capture edge of a write arriving in the same system clock cycle as the rising edge of chip select. The bench provokes this by changing SCLK and `csN` on the same clock edge, so both arrive through identical synchronizers together. The design must treat this as an abort. The bench judges it by reading the register back afterwards and expecting its previous value. Aborts after fewer bits are mixed into the random traffic and judged the same way.

// File: rtl/serhost_pkg.sv
package serhost_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic shiftEn;   // capture one input bit
    logic cmdLatch;  // last command bit captured this cycle
    logic commit;    // last data bit captured this cycle
    logic loadOut;   // first data-phase launch: load read data
    logic shiftOut;  // later data-phase launch: advance read data
    logic sdiBit;    // synchronized serial input value
  } hostStrb_t;

endpackage

// File: rtl/serhost_sync.sv
module serhost_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < STAGES; k++) stage[k] <= RST_VAL;
    end else begin
      stage[0] <= din;
      for (int k = 1; k < STAGES; k++) stage[k] <= stage[k-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/serhost_ctrl.sv
module serhost_ctrl
  import serhost_pkg::*;
#(
  parameter int CMD_BITS = 8,
  parameter int FRAME_BITS = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclk,
  input  logic      csN,
  input  logic      sdi,
  input  logic      edgeSel,
  output hostStrb_t strb,
  output logic      sdoOe
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_FIRST = CNT_W'(CMD_BITS);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FRAME_DONE = CNT_W'(FRAME_BITS);

  logic [2:0] rawIn;
  logic [2:0] syncOut;
  logic sclkS, csS, sdiS, sclkPrev;
  logic riseStb, fallStb, sampleStb, launchStb;
  logic active, taking, inData;
  logic [CNT_W-1:0] bitCnt;
  logic dataStarted;

  assign rawIn = {sclk, csN, sdi};

  serhost_sync #(
    .WIDTH(3),
    .STAGES(SYNC_STAGES),
    .RST_VAL(3'b010)
  ) uSync (
    .clk (clk),
    .rstN(rstN),
    .din (rawIn),
    .dout(syncOut)
  );

  assign sclkS = syncOut[2];
  assign csS   = syncOut[1];
  assign sdiS  = syncOut[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkS;
  end

  assign riseStb   = sclkS & ~sclkPrev;
  assign fallStb   = ~sclkS & sclkPrev;
  assign sampleStb = edgeSel ? riseStb : fallStb;
  assign launchStb = edgeSel ? fallStb : riseStb;

  // chip select high wins over any serial edge seen in the same cycle
  assign active = ~csS;
  assign taking = active && sampleStb && (bitCnt < FRAME_DONE);
  assign inData = (bitCnt >= DATA_FIRST) && (bitCnt < FRAME_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt      <= '0;
      dataStarted <= 1'b0;
      sdoOe       <= 1'b0;
    end else if (!active) begin
      bitCnt      <= '0;
      dataStarted <= 1'b0;
      sdoOe       <= 1'b0;
    end else begin
      if (taking) bitCnt <= bitCnt + 1'b1;
      if (launchStb && inData) begin
        dataStarted <= 1'b1;
        sdoOe       <= 1'b1;
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.sdiBit   = sdiS;
    strb.shiftEn  = taking;
    strb.cmdLatch = taking && (bitCnt == CMD_LAST);
    strb.commit   = taking && (bitCnt == FRAME_LAST);
    strb.loadOut  = active && launchStb && inData && !dataStarted;
    strb.shiftOut = active && launchStb && inData && dataStarted;
  end

  // R6
  cs_idle_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> !sdoOe);

  // R6
  cs_idle_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> (bitCnt == '0));

  // R3 R4
  oe_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdoOe) |-> $past(launchStb && (bitCnt >= DATA_FIRST)));

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FRAME_DONE);

endmodule

// File: rtl/serhost_dpath.sv
module serhost_dpath
  import serhost_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int NUM_REGS = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  hostStrb_t strb,
  output logic      sdoBit
);

  localparam int CMD_BITS = ADDR_W + 1;
  localparam int SH_W = (CMD_BITS > DATA_W) ? CMD_BITS : DATA_W;

  logic [SH_W-1:0] shiftReg;
  logic [ADDR_W-1:0] cmdAddr;
  logic cmdRnw;
  logic [CMD_BITS-1:0] cmdNext;
  logic [DATA_W-1:0] wdata, rdData, outShift;
  logic [NUM_REGS-1:0][DATA_W-1:0] regFile;
  logic [NUM_REGS-1:0] wrSel;
  logic inRange, wrEn;

  assign cmdNext = {shiftReg[CMD_BITS-2:0], strb.sdiBit};
  assign wdata   = {shiftReg[DATA_W-2:0], strb.sdiBit};
  assign inRange = (32'(cmdAddr) < NUM_REGS);
  assign wrEn    = strb.commit && !cmdRnw && inRange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      cmdAddr  <= '0;
      cmdRnw   <= 1'b0;
    end else begin
      if (strb.shiftEn) shiftReg <= {shiftReg[SH_W-2:0], strb.sdiBit};
      if (strb.cmdLatch) begin
        cmdAddr <= cmdNext[CMD_BITS-1:1];
        cmdRnw  <= cmdNext[0];
      end
    end
  end

  // one write select per register
  for (genvar g = 0; g < NUM_REGS; g++) begin : gSel
    assign wrSel[g] = wrEn && (cmdAddr == ADDR_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regFile <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (wrSel[i]) regFile[i] <= wdata;
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (inRange && (cmdAddr == ADDR_W'(i))) rdData = regFile[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              outShift <= '0;
    else if (strb.loadOut)  outShift <= rdData;
    else if (strb.shiftOut) outShift <= {outShift[DATA_W-2:0], 1'b0};
  end

  assign sdoBit = cmdRnw ? outShift[DATA_W-1] : 1'b0;

  // R2
  wr_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !cmdRnw && inRange) |=> (rdData == $past(wdata)));

  // R8
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !inRange) |=> $stable(regFile));

  // R7
  no_stray_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(regFile));

endmodule

// File: rtl/serhost_port.sv
module serhost_port
  import serhost_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int NUM_REGS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic csN,
  input  logic sdi,
  input  logic edgeSel,
  output logic sdoData,
  output logic sdoOe
);

  localparam int CMD_BITS = ADDR_W + 1;
  localparam int FRAME_BITS = CMD_BITS + DATA_W;

  hostStrb_t strb;
  logic sdoBit;

  serhost_ctrl #(
    .CMD_BITS(CMD_BITS),
    .FRAME_BITS(FRAME_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclk   (sclk),
    .csN    (csN),
    .sdi    (sdi),
    .edgeSel(edgeSel),
    .strb   (strb),
    .sdoOe  (sdoOe)
  );

  serhost_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NUM_REGS(NUM_REGS)
  ) uDpath (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .sdoBit(sdoBit)
  );

  assign sdoData = sdoOe & sdoBit;

  // R6
  hiz_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sdoOe |-> !sdoData);

endmodule

// File: tb/serhost_port_test.sv
module serhost_port_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic sdi = 1'b0;
  logic edgeSel = 1'b1;
  logic sdoData, sdoOe;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] model [8];

  always #10 clk = ~clk;

  serhost_port uut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdi(sdi),
    .edgeSel(edgeSel), .sdoData(sdoData), .sdoOe(sdoOe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] expRead(input logic [6:0] addr);
    return (addr < 7'd8) ? model[addr[2:0]] : 8'h00;
  endfunction

  // abortAt: -1 none, 1..15 raise csN before that bit, 16 with the last capture edge
  task automatic txn(input logic es, input logic rd, input logic [6:0] addr,
                     input logic [7:0] wd, input int abortAt, output logic [7:0] rdata);
    logic [15:0] frame;
    logic [7:0] exp;
    string tg;
    exp = expRead(addr);
    frame = {addr, rd, wd};
    rdata = 8'h00;
    @(negedge clk);
    edgeSel = es;
    sclk = es;
    waitN(4);
    csN = 1'b0;
    waitN(6);
    for (int b = 0; b < 16; b++) begin
      if (abortAt == b && b > 0) begin
        csN = 1'b1;
        break;
      end
      sclk = ~es;
      sdi = ~frame[15-b];
      waitN(6);
      sdi = frame[15-b];
      waitN(6);
      if (b < 8) begin
        check(rd ? "R4 oe during command" : "R3 oe during command", {7'd0, sdoOe}, 8'd0);
      end else begin
        check(rd ? "R4 oe in data phase" : "R3 oe in data phase", {7'd0, sdoOe}, 8'd1);
        if (rd) begin
          tg = (addr >= 7'd8) ? "R8 unmapped read bit" : (es ? "R4 R5 read bit, fall launch" : "R4 R5 read bit, rise launch");
          check(tg, {7'd0, sdoData}, {7'd0, exp[15-b]});
          rdata[15-b] = sdoData;
        end else begin
          check("R3 write drives low", {7'd0, sdoData}, 8'd0);
        end
      end
      sclk = es;
      if (abortAt == 16 && b == 15) csN = 1'b1;
      waitN(6);
    end
    csN = 1'b1;
    waitN(6);
    check("R6 oe after deselect", {7'd0, sdoOe}, 8'd0);
    if (!rd && abortAt < 0 && addr < 7'd8) model[addr[2:0]] = wd;
  endtask

  task automatic readCheck(input string tag, input logic es, input logic [6:0] addr);
    logic [7:0] got;
    logic [7:0] exp;
    exp = expRead(addr);
    txn(es, 1'b1, addr, 8'h00, -1, got);
    check(tag, got, exp);
  endtask

  task automatic writeReg(input logic es, input logic [6:0] addr, input logic [7:0] wd, input int abortAt);
    logic [7:0] dummy;
    txn(es, 1'b0, addr, wd, abortAt, dummy);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    void'($urandom(32'd20240611));
    waitN(5);
    rstN = 1'b1;
    waitN(3);
    // R9 reset state
    check("R9 oe after reset", {7'd0, sdoOe}, 8'd0);
    for (int a = 0; a < 8; a++) readCheck("R9 register reset value", 1'b1, 7'(a));

    // R1 R2 write then read, both edge settings
    writeReg(1'b1, 7'd3, 8'hA5, -1);
    readCheck("R2 readback reg3", 1'b1, 7'd3);
    writeReg(1'b0, 7'd5, 8'h3C, -1);
    readCheck("R5 readback reg5 rise launch", 1'b0, 7'd5);
    readCheck("R5 readback reg3 cross mode", 1'b0, 7'd3);
    writeReg(1'b1, 7'd6, 8'h81, -1);
    readCheck("R1 msb first reg6", 1'b1, 7'd6);

    // R8 unmapped
    writeReg(1'b1, 7'd9, 8'hFF, -1);
    readCheck("R8 unmapped read zero", 1'b1, 7'd9);
    readCheck("R8 reg1 untouched", 1'b1, 7'd1);
    writeReg(1'b0, 7'd127, 8'h5A, -1);
    readCheck("R8 top address read zero", 1'b0, 7'd127);

    // R7 aborts
    writeReg(1'b1, 7'd3, 8'h00, 10);
    readCheck("R7 abort after ten bits", 1'b1, 7'd3);
    writeReg(1'b1, 7'd3, 8'h11, 16);
    readCheck("R7 abort same cycle as last edge", 1'b1, 7'd3);
    writeReg(1'b0, 7'd5, 8'hEE, 16);
    readCheck("R7 abort same cycle rise mode", 1'b0, 7'd5);

    // R6 sclk toggling while deselected
    for (int t = 0; t < 5; t++) begin
      sclk = ~sclk; waitN(6);
    end
    check("R6 oe while deselected", {7'd0, sdoOe}, 8'd0);
    writeReg(1'b1, 7'd0, 8'h77, -1);
    readCheck("R6 frame after idle toggles", 1'b1, 7'd0);

    // random traffic
    for (int n = 0; n < 110; n++) begin
      logic es, rd;
      logic [6:0] addr;
      logic [7:0] wd, got;
      int ab;
      int r;
      r = int'($urandom % 1000);
      es = 1'($urandom);
      rd = 1'($urandom);
      addr = ($urandom % 6 == 0) ? 7'($urandom) : 7'($urandom % 8);
      wd = 8'($urandom);
      ab = (r % 6 == 0) ? 1 + (r % 16) : -1;
      if (rd) begin
        txn(es, 1'b1, addr, 8'h00, ab, got);
        if (ab < 0) check("R4 random read byte", got, expRead(addr));
      end else begin
        writeReg(es, addr, wd, ab);
        if (ab >= 0) readCheck("R7 random abort keeps value", ~es, addr);
        else readCheck("R2 random write readback", ~es, addr);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule